// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block watches the first six bytes of every received Ethernet frame, which carry the destination address. It decides whether the frame should be kept. Bytes arrive one per cycle when `byte_valid` is high. `frame_start` marks the first byte of a frame, and `frame_end` marks the last byte. While the bytes arrive, the block assembles the address and runs a CRC-32 over it. The address is then sorted into one of three classes: unicast, multicast or broadcast.

Six independent enable bits in `filt_ctrl` turn on the acceptance rules:

- accept a whole class;
- accept on a hash-table hit, for the unicast or the multicast class;
- accept on an exact match with the programmed station address.

The frame is accepted when any enabled rule matches.

The result appears as a single-cycle strobe in the cycle after the sixth address byte is taken. The same strobe, with a reject verdict, follows the last byte of a frame that ends too early. Frame storage, frame CRC checking and wake-up handling belong to other blocks.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset `verdict_valid` and `verdict_accept` are 0, and when `filt_ctrl` is all zero every frame gets a reject verdict.
- R2: Byte k of the frame (k = 0..5) is address byte k, mapped to address bits [8k+7:8k]. An address of all ones is broadcast. Otherwise an address with bit 0 equal to 1 is multicast. All remaining addresses are unicast.
- R3: With `filt_ctrl[0]` set, every unicast frame is accepted.
- R4: With `filt_ctrl[1]` set, every broadcast frame is accepted.
- R5: With `filt_ctrl[2]` set, every multicast (non-broadcast) frame is accepted.
- R6: With `filt_ctrl[3]` set, a unicast frame is accepted when `hash_table[idx]` is 1.
- R7: With `filt_ctrl[4]` set, a multicast (non-broadcast) frame is accepted when `hash_table[idx]` is 1. A broadcast address is never accepted through this rule.
- R8: With `filt_ctrl[5]` set, a frame whose address equals `station_addr` (same byte mapping as R2) is accepted, whatever its class.
- R9: The verdict is the OR of all enabled rules.
- R10: `verdict_valid` is high for exactly one cycle, the cycle after the edge that takes the sixth address byte. Cycles with `byte_valid` low are skipped. Bytes after the sixth, and bytes outside a frame, produce no verdict. `filt_ctrl`, `station_addr` and `hash_table` are read in the verdict cycle.
- R11: A frame whose `frame_end` byte is one of its first five bytes yields `verdict_valid` = 1 with `verdict_accept` = 0 in the next cycle.
- R12: `frame_start` always begins a new frame, even while an earlier frame's address is incomplete. The unfinished frame produces no verdict.
- R13: The hash index `idx` is bits [5:0] of a CRC register. The register uses the reflected polynomial 0xEDB88320, is preset to all ones, takes each address byte LSB first, and is not inverted at the end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_valid | input | 1 | A byte is present on `byte_data` |
| frame_start | input | 1 | The current byte is the first of a frame |
| frame_end | input | 1 | The current byte is the last of a frame |
| byte_data | input | 8 | Received byte |
| station_addr | input | 48 | Station address, byte 0 in bits [7:0] |
| hash_table | input | 64 | Hash table, one bit per index |
| filt_ctrl | input | 6 | Rule enables |
| verdict_valid | output | 1 | Verdict strobe |
| verdict_accept | output | 1 | 1 = keep the frame; meaningful while `verdict_valid` is high |

## Verification
The assertions run on every cycle and check these rules:

- an accept is only ever flagged together with the strobe;
- an all-zero control word never accepts;
- a truncated frame never accepts;
- a captured address of each class is accepted whenever its class-wide enable is set;
- an exact station match is accepted when its enable is set.

Some behaviour is left to the bench scenarios, which compare each verdict with a CRC model written inside the bench. These are the hash-rule outcomes, the exclusion of broadcast from the multicast hash rule, the exact strobe cycle across idle gaps, and the absence of verdicts for restarted frames and for trailing bytes.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    localparam int ADDR_BYTES = 6;
    localparam int ADDR_W     = ADDR_BYTES * 8;
    localparam int HASH_BITS  = 6;
    localparam int CTRL_W     = 6;
    localparam logic [31:0] CRC_POLY = 32'hEDB88320;

    // rule enable positions inside the control word
    localparam int EN_UC_ALL  = 0;
    localparam int EN_BC_ALL  = 1;
    localparam int EN_MC_ALL  = 2;
    localparam int EN_UC_HASH = 3;
    localparam int EN_MC_HASH = 4;
    localparam int EN_STATION = 5;

    typedef enum logic [1:0] {
        CLS_UNICAST   = 2'd0,
        CLS_MULTICAST = 2'd1,
        CLS_BROADCAST = 2'd2
    } addr_class_e;

    // one byte through a reflected CRC-32, LSB first
    function automatic logic [31:0] crc_byte(input logic [31:0] c_in, input logic [7:0] d);
        logic [31:0] c;
        c = c_in ^ {24'd0, d};
        for (int b = 0; b < 8; b++) begin
            c = c[0] ? ((c >> 1) ^ CRC_POLY) : (c >> 1);
        end
        return c;
    endfunction
endpackage

// File: rtl/rxf_capture.sv
module rxf_capture
    import rxf_pkg::*;
#(
    parameter int N_BYTES = ADDR_BYTES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 in_first,
    input  logic                 in_last,
    input  logic [7:0]           in_data,
    output logic                 take,
    output logic                 take_first,
    output logic [N_BYTES*8-1:0] addr,
    output logic                 done,
    output logic                 short_frame
);
    localparam int CNT_W = $clog2(N_BYTES + 1);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(N_BYTES - 1);

    typedef struct packed {
        logic                 active;
        logic [CNT_W-1:0]     cnt;
        logic [N_BYTES*8-1:0] addr;
        logic                 done;
        logic                 short_f;
    } cap_t;

    cap_t s_d, s_q;
    logic [CNT_W-1:0] idx;

    always_comb begin
        s_d          = s_q;
        s_d.done     = 1'b0;
        s_d.short_f  = 1'b0;
        take         = in_valid && (in_first || s_q.active);
        take_first   = take && in_first;
        idx          = in_first ? '0 : s_q.cnt;
        if (take) begin
            s_d.addr[int'(idx)*8 +: 8] = in_data;
            s_d.cnt    = idx + 1'b1;
            s_d.active = 1'b1;
            if (idx == LAST_IDX) begin
                s_d.done   = 1'b1;
                s_d.active = 1'b0;
            end else if (in_last) begin
                s_d.short_f = 1'b1;
                s_d.active  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign addr        = s_q.addr;
    assign done        = s_q.done;
    assign short_frame = s_q.short_f;
endmodule

// File: rtl/rxf_crc_hash.sv
module rxf_crc_hash
    import rxf_pkg::*;
#(
    parameter int IDX_W = HASH_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             take_first,
    input  logic [7:0]       in_data,
    output logic [IDX_W-1:0] hash_idx
);
    typedef struct packed {
        logic [31:0] crc;
    } crc_t;

    crc_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (take) c_d.crc = crc_byte(take_first ? 32'hFFFF_FFFF : c_q.crc, in_data);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{crc: 32'hFFFF_FFFF};
        else        c_q <= c_d;
    end

    assign hash_idx = c_q.crc[IDX_W-1:0];
endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
    import rxf_pkg::*;
#(
    parameter int AW    = ADDR_W,
    parameter int IDX_W = HASH_BITS
) (
    input  logic              [AW-1:0] addr,
    input  logic              [AW-1:0] station,
    input  logic     [(1<<IDX_W)-1:0]  table_bits,
    input  logic           [IDX_W-1:0] idx,
    input  logic          [CTRL_W-1:0] ctrl,
    output addr_class_e                cls,
    output logic                       accept
);
    logic hit;
    logic [CTRL_W-1:0] rule;

    always_comb begin
        if (&addr)        cls = CLS_BROADCAST;
        else if (addr[0]) cls = CLS_MULTICAST;
        else              cls = CLS_UNICAST;
        hit = table_bits[idx];
    end

    // one match term per enable bit
    for (genvar g = 0; g < CTRL_W; g++) begin : g_rule
        if (g == EN_UC_ALL) begin : g_uc
            assign rule[g] = ctrl[g] && (cls == CLS_UNICAST);
        end else if (g == EN_BC_ALL) begin : g_bc
            assign rule[g] = ctrl[g] && (cls == CLS_BROADCAST);
        end else if (g == EN_MC_ALL) begin : g_mc
            assign rule[g] = ctrl[g] && (cls == CLS_MULTICAST);
        end else if (g == EN_UC_HASH) begin : g_uch
            assign rule[g] = ctrl[g] && (cls == CLS_UNICAST) && hit;
        end else if (g == EN_MC_HASH) begin : g_mch
            assign rule[g] = ctrl[g] && (cls == CLS_MULTICAST) && hit;
        end else begin : g_st
            assign rule[g] = ctrl[g] && (addr == station);
        end
    end

    assign accept = |rule;
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import rxf_pkg::*;
#(
    parameter int N_BYTES = ADDR_BYTES,
    parameter int IDX_W   = HASH_BITS
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   byte_valid,
    input  logic                   frame_start,
    input  logic                   frame_end,
    input  logic [7:0]             byte_data,
    input  logic [N_BYTES*8-1:0]   station_addr,
    input  logic [(1<<IDX_W)-1:0]  hash_table,
    input  logic [CTRL_W-1:0]      filt_ctrl,
    output logic                   verdict_valid,
    output logic                   verdict_accept
);
    localparam int AW = N_BYTES * 8;

    logic          take, take_first, cap_done, cap_short, rule_accept;
    logic [AW-1:0] cap_addr;
    logic [IDX_W-1:0] hash_idx;
    addr_class_e   cls;

    rxf_capture #(.N_BYTES(N_BYTES)) u_cap (
        .clk(clk), .rst_n(rst_n),
        .in_valid(byte_valid), .in_first(frame_start), .in_last(frame_end),
        .in_data(byte_data),
        .take(take), .take_first(take_first),
        .addr(cap_addr), .done(cap_done), .short_frame(cap_short)
    );

    rxf_crc_hash #(.IDX_W(IDX_W)) u_crc (
        .clk(clk), .rst_n(rst_n),
        .take(take), .take_first(take_first), .in_data(byte_data),
        .hash_idx(hash_idx)
    );

    rxf_decide #(.AW(AW), .IDX_W(IDX_W)) u_dec (
        .addr(cap_addr), .station(station_addr), .table_bits(hash_table),
        .idx(hash_idx), .ctrl(filt_ctrl), .cls(cls), .accept(rule_accept)
    );

    assign verdict_valid  = cap_done | cap_short;
    assign verdict_accept = cap_done & rule_accept;
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker
    import rxf_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CTRL_W-1:0] filt_ctrl,
    input logic [AW-1:0]     station_addr,
    input logic              verdict_valid,
    input logic              verdict_accept,
    input logic              cap_done,
    input logic              cap_short,
    input logic [AW-1:0]     cap_addr
);
    assert_accept_needs_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_accept |-> verdict_valid);

    assert_zero_ctrl_rejects_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_ctrl == '0) |-> !verdict_accept);

    assert_short_rejects_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cap_short |-> (verdict_valid && !verdict_accept));

    assert_done_short_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(cap_done && cap_short));

    assert_uc_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_done && !cap_addr[0] && filt_ctrl[EN_UC_ALL]) |-> verdict_accept);

    assert_bc_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_done && (&cap_addr) && filt_ctrl[EN_BC_ALL]) |-> verdict_accept);

    assert_mc_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_done && cap_addr[0] && !(&cap_addr) && filt_ctrl[EN_MC_ALL]) |-> verdict_accept);

    assert_station_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_done && filt_ctrl[EN_STATION] && cap_addr == station_addr) |-> verdict_accept);
endmodule

bind rx_addr_filter rxf_checker #(.AW(N_BYTES*8)) u_chk (
    .clk(clk), .rst_n(rst_n), .filt_ctrl(filt_ctrl), .station_addr(station_addr),
    .verdict_valid(verdict_valid), .verdict_accept(verdict_accept),
    .cap_done(cap_done), .cap_short(cap_short), .cap_addr(cap_addr)
);

// File: tb/tb_rx_addr_filter.sv
module tb_rx_addr_filter;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_valid = 1'b0, frame_start = 1'b0, frame_end = 1'b0;
    logic [7:0]  byte_data = '0;
    logic [47:0] station_addr = '0;
    logic [63:0] hash_table = '0;
    logic [5:0]  filt_ctrl = '0;
    logic        verdict_valid, verdict_accept;

    int checks = 0, errors = 0, cycles = 0;
    bit finished = 0;
    bit pend = 0, pexp = 0;
    string preq = "";

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_addr_filter dut (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .frame_start(frame_start),
        .frame_end(frame_end), .byte_data(byte_data), .station_addr(station_addr),
        .hash_table(hash_table), .filt_ctrl(filt_ctrl),
        .verdict_valid(verdict_valid), .verdict_accept(verdict_accept)
    );

    // model of R13, written bit by bit
    function automatic logic [5:0] model_idx(input logic [47:0] a);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < 48; i++) begin
            logic fb;
            fb = a[i] ^ c[0];
            c = c >> 1;
            if (fb) c = c ^ 32'hEDB88320;
        end
        return c[5:0];
    endfunction

    // model of R2..R9
    function automatic bit model_accept(input logic [47:0] a);
        bit bc, mc, uc, hit;
        bc  = (a == '1);
        mc  = a[0] && !bc;
        uc  = !a[0];
        hit = hash_table[model_idx(a)];
        return (uc && filt_ctrl[0]) || (bc && filt_ctrl[1]) || (mc && filt_ctrl[2]) ||
               (uc && filt_ctrl[3] && hit) || (mc && filt_ctrl[4] && hit) ||
               (filt_ctrl[5] && a == station_addr);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one cycle; consume an expected verdict or demand silence (R10)
    task automatic tick();
        @(negedge clk);
        if (pend) begin
            check(verdict_valid === 1'b1, {preq, " strobe"}, int'(verdict_valid), 1);
            check(verdict_accept === pexp, preq, int'(verdict_accept), int'(pexp));
            pend = 0;
        end else begin
            check(verdict_valid === 1'b0, "R10 no stray strobe", int'(verdict_valid), 0);
        end
    endtask

    task automatic send(input logic [47:0] a, input int n, input bit with_end,
                        input bit gaps, input string req);
        for (int i = 0; i < n; i++) begin
            if (gaps && i > 0 && ($urandom % 3) == 0) begin
                tick();
                byte_valid = 0; frame_start = 0; frame_end = 0;
            end
            tick();
            byte_valid  = 1;
            frame_start = (i == 0);
            frame_end   = with_end && (i == n - 1);
            byte_data   = (i < 6) ? a[8*i +: 8] : 8'($urandom);
            if (i == 5) begin
                pend = 1; pexp = model_accept(a); preq = req;
            end else if (with_end && i == n - 1 && i < 5) begin
                pend = 1; pexp = 0; preq = "R11 short frame";
            end
        end
        tick();
        byte_valid = 0; frame_start = 0; frame_end = 0;
        tick();
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG && !finished) begin
                errors++;
                $display("FAIL watchdog expired");
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [47:0] a, uca, mca;
        void'($urandom(32'd2718));
        station_addr = 48'h5A4B_3C2D_1E02;
        repeat (3) @(negedge clk);
        check(verdict_valid === 0 && verdict_accept === 0, "R1 reset outputs",
              int'(verdict_valid), 0);
        rst_n = 1;
        tick();

        // R1: zero control rejects everything
        filt_ctrl = 0; hash_table = '1;
        send(48'hFFFF_FFFF_FFFF, 6, 1, 0, "R1 zero ctrl bcast");
        send(station_addr, 6, 1, 0, "R1 zero ctrl station");
        check(model_accept(station_addr) == 0, "R1 model", 0, 0);

        // R3 / R4 / R5 class enables, R2 classification
        filt_ctrl = 6'b000001;
        send(48'h1234_5678_9A00, 7, 1, 0, "R3 unicast all");
        send(48'h1234_5678_9A01, 6, 1, 0, "R2 mcast not unicast");
        filt_ctrl = 6'b000010;
        send(48'hFFFF_FFFF_FFFF, 6, 1, 0, "R4 broadcast all");
        send(48'hFFFF_FFFF_FFFE, 6, 1, 0, "R2 near-broadcast unicast");
        filt_ctrl = 6'b000100;
        send(48'h0000_0000_0001, 8, 1, 0, "R5 multicast all");
        send(48'hFFFF_FFFF_FFFF, 6, 1, 0, "R2 broadcast not multicast");

        // R6 / R7 / R13 hash rules
        uca = 48'hA1B2_C3D4_E5F6; mca = 48'h0100_5E00_00FB;
        filt_ctrl = 6'b001000;
        hash_table = 64'd1 << model_idx(uca);
        send(uca, 6, 1, 1, "R6 unicast hash hit");
        hash_table = ~(64'd1 << model_idx(uca));
        send(uca, 6, 1, 1, "R6 unicast hash miss");
        send(mca, 6, 1, 0, "R6 multicast ignored");
        filt_ctrl = 6'b010000;
        hash_table = 64'd1 << model_idx(mca);
        send(mca, 6, 1, 1, "R7 multicast hash hit");
        hash_table = '1;
        send(48'hFFFF_FFFF_FFFF, 6, 1, 0, "R7 broadcast excluded");
        send(uca, 6, 1, 0, "R7 unicast ignored");

        // R8 station match
        filt_ctrl = 6'b100000; hash_table = '0;
        send(station_addr, 6, 1, 1, "R8 station match");
        send(station_addr ^ 48'h0100_0000_0000, 6, 1, 0, "R8 station mismatch");

        // R9 OR combination
        filt_ctrl = 6'b100100;
        send(station_addr, 6, 1, 0, "R9 or station");
        send(mca, 6, 1, 0, "R9 or multicast");

        // R11 short frames, R12 restart
        filt_ctrl = 6'b111111;
        send(48'hFFFF_FFFF_FFFF, 3, 1, 0, "R11");
        send(48'hFFFF_FFFF_FFFF, 1, 1, 0, "R11");
        send(48'hFFFF_FFFF_FFFF, 4, 0, 0, "R12 abandoned");
        filt_ctrl = 6'b000001;
        send(48'h1111_2222_3300, 6, 1, 1, "R12 restart new frame");

        // R10: bytes outside a frame produce nothing
        tick(); byte_valid = 1; byte_data = 8'h55;
        repeat (8) tick();
        byte_valid = 0;
        tick();

        // random mix of R2..R13
        for (int k = 0; k < 400; k++) begin
            int sel;
            filt_ctrl  = 6'($urandom);
            hash_table = {$urandom, $urandom};
            sel = $urandom % 5;
            case (sel)
                0: a = station_addr;
                1: a = '1;
                2: a = {$urandom, 16'($urandom)} | 48'd1;
                default: a = {$urandom, 16'($urandom)};
            endcase
            if (($urandom % 10) == 0)
                send(a, 1 + $urandom % 5, 1, 1, "R11 random short");
            else
                send(a, 6 + $urandom % 4, ($urandom % 2) == 0, 1, "R9 random frame");
        end

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule